// File: doc/BRIEF.md
# Raster Panel Timing Generator

This block produces the scan timing for a raster display panel. A dot counter moves forward on each cycle where the pixel-clock-enable input is high, and a line counter moves forward each time the dot counter wraps. The counters are decoded into active-high horizontal sync, vertical sync and data-enable, and the block also reports the current position and one-cycle start-of-frame and end-of-frame pulses. Every timing edge comes from a packed register that holds a start/end pair. The start is inclusive and the end is exclusive.

Software loads the pairs through a simple write strobe port. The pairs land in a staging copy and move to the working copy only while the block is idle or at the moment a frame wraps, so no frame is ever built from two timing setups. Control is a state machine with three states: `ST_IDLE`, `ST_RUN` and `ST_DRAIN`. The transitions are:

- START: `ST_IDLE` to `ST_RUN`, when enable is set and stop-request is clear.
- STOP_REQ: `ST_RUN` to `ST_DRAIN`, when stop-request is set.
- DRAIN_DONE: `ST_DRAIN` to `ST_IDLE`, when the frame wraps.
- QUICK: `ST_RUN` or `ST_DRAIN` to `ST_IDLE`, when enable is clear.

A normal stop therefore finishes the frame that is on screen. A quick stop halts on the next clock. Four event outputs can each be masked: start of frame, end of frame, normal-stop done and quick-stop done.

Top module: `lcd_raster_timer`

## Requirements
- R1: Address 0 is the control word: bit 0 is enable, bit 1 is stop-request, and bits 5:2 are the event mask for sof, eof, stop-done and quick-done in that order. Addresses 1 to 5 hold the hsync pair, the vsync pair, the totals pair, the horizontal visible pair and the vertical visible pair. Each pair keeps its start in bits 31:16 and its end in bits 15:0. For the totals pair, the upper half is the dot count per line and the lower half is the line count per frame.
- R2: While running, the dot counter advances only on cycles with pix_en high. At horizontal total minus 1 it wraps to 0 and advances the line counter. The line counter wraps to 0 at vertical total minus 1. When pix_en is low, both counters hold.
- R3: o_hsync is high exactly when running and the dot lies in [hsync start, hsync end). o_vsync is high exactly when running and the line lies in [vsync start, vsync end).
- R4: o_de is high only when the dot lies inside the horizontal visible window and the line lies inside the vertical visible window, both windows half-open.
- R5: o_sof is a one-cycle pulse in the cycle the counters show (0,0) at a start or a frame wrap. o_eof is a one-cycle pulse in the cycle the counters first show the last dot of the last visible line.
- R6: Writes to addresses 1 to 5 take effect only while idle or at the frame wrap. A frame in progress keeps its timing.
- R7: From idle, enable=1 with stop-request=0 starts scanning at (0,0) one cycle later, with o_sof high.
- R8: Stop-request set while running lets the current frame finish. At the wrap, the block goes idle and pulses o_irq[2].
- R9: Clearing enable while running or draining forces idle on the next clock, with all outputs cleared, and pulses o_irq[3].
- R10: o_irq bit k is the event in the list above ANDed with mask bit k. A masked event never appears on o_irq.
- R11: Under reset and while idle, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pix_en | input | 1 | Dot clock enable |
| o_hsync | output | 1 | Horizontal sync, active high |
| o_vsync | output | 1 | Vertical sync, active high |
| o_de | output | 1 | Data enable |
| o_x | output | 16 | Current dot position |
| o_y | output | 16 | Current line position |
| o_sof | output | 1 | Start-of-frame pulse |
| o_eof | output | 1 | End-of-frame pulse |
| o_irq | output | 4 | Masked events: sof, eof, stop-done, quick-done |

## Verification
The bench rewrites the timing in the middle of a frame. A design that applies the new pairs at once would show a line longer than the old total before the next o_sof. The bench also stalls pix_en in irregular patterns, which exposes a counter that keeps moving on idle cycles or that fires o_eof again while it waits on the last visible dot. It then performs a normal stop, a quick stop and a run with every event masked: a design that stops too early, skips the done pulse or lets a masked event through differs from the cycle-accurate reference model at the exact cycle where the error occurs.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int PAIR_W = 16;
    localparam int IRQ_N  = 4;

    localparam int IRQ_SOF   = 0;
    localparam int IRQ_EOF   = 1;
    localparam int IRQ_STOP  = 2;
    localparam int IRQ_QUICK = 3;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_STOP_BIT = 1;
    localparam int CTL_MASK_LSB = 2;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_HSYNC = 3'd1;
    localparam logic [2:0] ADDR_VSYNC = 3'd2;
    localparam logic [2:0] ADDR_TOTAL = 3'd3;
    localparam logic [2:0] ADDR_HWIN  = 3'd4;
    localparam logic [2:0] ADDR_VWIN  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } scan_state_e;

    // first = inclusive start (upper half), last = exclusive end (lower half)
    typedef struct packed {
        logic [PAIR_W-1:0] first;
        logic [PAIR_W-1:0] last;
    } pair_t;

    typedef struct packed {
        pair_t hsync;
        pair_t vsync;
        pair_t total;
        pair_t hwin;
        pair_t vwin;
    } timing_t;

endpackage

// File: rtl/lcdt_regfile.sv
module lcdt_regfile
    import lcdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 2 * PAIR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic              ctl_en,
    output logic              ctl_stop,
    output logic [IRQ_N-1:0]  irq_mask,
    output timing_t           act_q,
    output timing_t           act_nxt
);

    localparam int CTL_W = CTL_MASK_LSB + IRQ_N;

    logic [CTL_W-1:0] ctl_q;
    timing_t          stage_q;
    pair_t            wr_pair;

    assign wr_pair  = pair_t'(wr_data);
    assign ctl_en   = ctl_q[CTL_EN_BIT];
    assign ctl_stop = ctl_q[CTL_STOP_BIT];
    assign irq_mask = ctl_q[CTL_MASK_LSB +: IRQ_N];

    // Working copy follows staging only while idle or at a frame wrap.
    always_comb begin
        act_nxt = load ? stage_q : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            stage_q <= '0;
            act_q   <= '0;
        end else begin
            act_q <= act_nxt;
            if (wr_en) begin
                case (3'(wr_addr))
                    ADDR_CTRL:  ctl_q         <= wr_data[CTL_W-1:0];
                    ADDR_HSYNC: stage_q.hsync <= wr_pair;
                    ADDR_VSYNC: stage_q.vsync <= wr_pair;
                    ADDR_TOTAL: stage_q.total <= wr_pair;
                    ADDR_HWIN:  stage_q.hwin  <= wr_pair;
                    ADDR_VWIN:  stage_q.vwin  <= wr_pair;
                    default:    ;
                endcase
            end
        end
    end

endmodule

// File: rtl/lcdt_fsm.sv
module lcdt_fsm
    import lcdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_en,
    input  logic        ctl_stop,
    input  logic        frame_wrap,
    output scan_state_e state_q,
    output scan_state_e state_nxt,
    output logic        stop_done,
    output logic        quick_done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt  = state_q;
        stop_done  = 1'b0;
        quick_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl_en && !ctl_stop) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!ctl_en) begin
                    state_nxt  = ST_IDLE;
                    quick_done = 1'b1;
                end else if (ctl_stop) begin
                    state_nxt = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!ctl_en) begin
                    state_nxt  = ST_IDLE;
                    quick_done = 1'b1;
                end else if (frame_wrap) begin
                    state_nxt = ST_IDLE;
                    stop_done = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    a_r9_quick_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !ctl_en) |=> (state_q == ST_IDLE));

    a_r7_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctl_en && !ctl_stop) |=> (state_q == ST_RUN));

    a_r8_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && ctl_en && !frame_wrap) |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  scan_state_e       state_q,
    input  scan_state_e       state_nxt,
    input  timing_t           act_q,
    input  timing_t           act_nxt,
    input  logic [IRQ_N-1:0]  irq_mask,
    input  logic              stop_done,
    input  logic              quick_done,
    output logic              frame_wrap,
    output logic              o_hsync,
    output logic              o_vsync,
    output logic              o_de,
    output logic [PAIR_W-1:0] o_x,
    output logic [PAIR_W-1:0] o_y,
    output logic              o_sof,
    output logic              o_eof,
    output logic [IRQ_N-1:0]  o_irq
);

    localparam logic [PAIR_W-1:0] ONE = PAIR_W'(1);

    logic              running, run_n, moved, last_dot, last_line;
    logic [PAIR_W-1:0] x_q, y_q, x_n, y_n;
    logic              hs_n, vs_n, de_n, sof_n, eof_n;
    logic [IRQ_N-1:0]  ev_n;

    function automatic logic in_pair(input logic [PAIR_W-1:0] v, input pair_t p);
        return (v >= p.first) && (v < p.last);
    endfunction

    always_comb begin
        running    = (state_q != ST_IDLE);
        run_n      = (state_nxt != ST_IDLE);
        last_dot   = (x_q == act_q.total.first - ONE);
        last_line  = (y_q == act_q.total.last - ONE);
        moved      = running && pix_en;
        frame_wrap = moved && last_dot && last_line;

        x_n = x_q;
        y_n = y_q;
        if (!running || !run_n) begin
            x_n = '0;
            y_n = '0;
        end else if (pix_en) begin
            if (last_dot) begin
                x_n = '0;
                y_n = last_line ? '0 : y_q + ONE;
            end else begin
                x_n = x_q + ONE;
            end
        end

        // Decode the next position against the timing that will be in force.
        hs_n  = run_n && in_pair(x_n, act_nxt.hsync);
        vs_n  = run_n && in_pair(y_n, act_nxt.vsync);
        de_n  = run_n && in_pair(x_n, act_nxt.hwin) && in_pair(y_n, act_nxt.vwin);
        sof_n = run_n && (!running || frame_wrap);
        eof_n = run_n && moved && (x_n == act_nxt.total.first - ONE)
                      && (y_n == act_nxt.vwin.last - ONE);

        ev_n            = '0;
        ev_n[IRQ_SOF]   = sof_n;
        ev_n[IRQ_EOF]   = eof_n;
        ev_n[IRQ_STOP]  = stop_done;
        ev_n[IRQ_QUICK] = quick_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q     <= '0;
            y_q     <= '0;
            o_hsync <= 1'b0;
            o_vsync <= 1'b0;
            o_de    <= 1'b0;
            o_sof   <= 1'b0;
            o_eof   <= 1'b0;
            o_irq   <= '0;
        end else begin
            x_q     <= x_n;
            y_q     <= y_n;
            o_hsync <= hs_n;
            o_vsync <= vs_n;
            o_de    <= de_n;
            o_sof   <= sof_n;
            o_eof   <= eof_n;
            o_irq   <= ev_n & irq_mask;
        end
    end

    assign o_x = x_q;
    assign o_y = y_q;

    a_r2_dot_below_total: assert property (@(posedge clk) disable iff (!rst_n)
        (running && act_q.total.first != '0) |-> (x_q < act_q.total.first));

    a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_n && !pix_en) |=> ($stable(x_q) && $stable(y_q)));

    a_r3_hsync_window: assert property (@(posedge clk) disable iff (!rst_n)
        o_hsync |-> (x_q >= act_q.hsync.first && x_q < act_q.hsync.last));

    a_r4_de_window: assert property (@(posedge clk) disable iff (!rst_n)
        o_de |-> (x_q >= act_q.hwin.first && x_q < act_q.hwin.last &&
                  y_q >= act_q.vwin.first && y_q < act_q.vwin.last));

    a_r5_sof_origin: assert property (@(posedge clk) disable iff (!rst_n)
        o_sof |-> (x_q == '0 && y_q == '0));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!o_hsync && !o_vsync && !o_de && x_q == '0 && y_q == '0));

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 2 * PAIR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pix_en,
    output logic              o_hsync,
    output logic              o_vsync,
    output logic              o_de,
    output logic [PAIR_W-1:0] o_x,
    output logic [PAIR_W-1:0] o_y,
    output logic              o_sof,
    output logic              o_eof,
    output logic [IRQ_N-1:0]  o_irq
);

    logic             ctl_en, ctl_stop, frame_wrap, load;
    logic             stop_done, quick_done;
    logic [IRQ_N-1:0] irq_mask;
    timing_t          act_q, act_nxt;
    scan_state_e      state_q, state_nxt;

    assign load = (state_q == ST_IDLE) || frame_wrap;

    lcdt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load     (load),
        .ctl_en   (ctl_en),
        .ctl_stop (ctl_stop),
        .irq_mask (irq_mask),
        .act_q    (act_q),
        .act_nxt  (act_nxt)
    );

    lcdt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_en     (ctl_en),
        .ctl_stop   (ctl_stop),
        .frame_wrap (frame_wrap),
        .state_q    (state_q),
        .state_nxt  (state_nxt),
        .stop_done  (stop_done),
        .quick_done (quick_done)
    );

    lcdt_scan u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en     (pix_en),
        .state_q    (state_q),
        .state_nxt  (state_nxt),
        .act_q      (act_q),
        .act_nxt    (act_nxt),
        .irq_mask   (irq_mask),
        .stop_done  (stop_done),
        .quick_done (quick_done),
        .frame_wrap (frame_wrap),
        .o_hsync    (o_hsync),
        .o_vsync    (o_vsync),
        .o_de       (o_de),
        .o_x        (o_x),
        .o_y        (o_y),
        .o_sof      (o_sof),
        .o_eof      (o_eof),
        .o_irq      (o_irq)
    );

    a_r6_frame_keeps_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !o_sof) |-> $stable(act_q));

    a_r10_sof_masked: assert property (@(posedge clk) disable iff (!rst_n)
        o_irq[IRQ_SOF] |-> o_sof);

    a_r10_eof_masked: assert property (@(posedge clk) disable iff (!rst_n)
        o_irq[IRQ_EOF] |-> o_eof);

    a_r8_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(o_irq[IRQ_QUICK:IRQ_STOP]));

endmodule

// File: tb/lcd_raster_timer_bench.sv
module lcd_raster_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pix_en = 1'b0;
    logic        o_hsync, o_vsync, o_de, o_sof, o_eof;
    logic [15:0] o_x, o_y;
    logic [3:0]  o_irq;

    int checks = 0;
    int errors = 0;
    int pix_mode = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    lcd_raster_timer u_lcd_raster_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_en(pix_en), .o_hsync(o_hsync), .o_vsync(o_vsync), .o_de(o_de),
        .o_x(o_x), .o_y(o_y), .o_sof(o_sof), .o_eof(o_eof), .o_irq(o_irq)
    );

    typedef struct packed {
        logic hs, vs, de;
        logic [15:0] x, y;
        logic sof, eof;
        logic [3:0] irq;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pr(input int first, input int last);
        return {16'(first), 16'(last)};
    endfunction

    function automatic logic win(input logic [15:0] v, input logic [31:0] p);
        return (v >= p[31:16]) && (v < p[15:0]);
    endfunction

    // ---------------- reference model (from the requirements) ----------------
    // index 1 hsync, 2 vsync, 3 totals, 4 h visible, 5 v visible
    logic [31:0] m_stage [1:5];
    logic [31:0] m_act   [1:5];
    logic [31:0] m_new   [1:5];
    logic [5:0]  m_ctl;
    int          m_st;
    logic [15:0] m_x, m_y;

    always @(posedge clk) begin
        exp_t e;
        logic [15:0] ht, vt, nx, ny;
        logic running, wrap, gd, qd, sof, eof, load;
        int nst;
        if (!rst_n) begin
            for (int i = 1; i <= 5; i++) begin m_stage[i] = '0; m_act[i] = '0; end
            m_ctl = '0; m_st = 0; m_x = '0; m_y = '0;
            e = '0;
        end else begin
            ht = m_act[3][31:16];
            vt = m_act[3][15:0];
            running = (m_st != 0);
            wrap = running && pix_en && (m_x == ht - 16'd1) && (m_y == vt - 16'd1);
            nst = m_st; gd = 0; qd = 0;
            case (m_st)
                0: if (m_ctl[0] && !m_ctl[1]) nst = 1;
                1: if (!m_ctl[0]) begin nst = 0; qd = 1; end
                   else if (m_ctl[1]) nst = 2;
                default: if (!m_ctl[0]) begin nst = 0; qd = 1; end
                         else if (wrap) begin nst = 0; gd = 1; end
            endcase
            load = (m_st == 0) || wrap;
            for (int i = 1; i <= 5; i++) m_new[i] = load ? m_stage[i] : m_act[i];
            nx = m_x; ny = m_y;
            if (m_st == 0 || nst == 0) begin nx = '0; ny = '0; end
            else if (pix_en) begin
                if (m_x == ht - 16'd1) begin
                    nx = '0;
                    ny = (m_y == vt - 16'd1) ? 16'd0 : m_y + 16'd1;
                end else nx = m_x + 16'd1;
            end
            sof = (nst != 0) && (m_st == 0 || wrap);
            eof = (nst != 0) && running && pix_en &&
                  (nx == m_new[3][31:16] - 16'd1) && (ny == m_new[5][15:0] - 16'd1);
            e.hs  = (nst != 0) && win(nx, m_new[1]);
            e.vs  = (nst != 0) && win(ny, m_new[2]);
            e.de  = (nst != 0) && win(nx, m_new[4]) && win(ny, m_new[5]);
            e.x   = nx;
            e.y   = ny;
            e.sof = sof;
            e.eof = eof;
            e.irq = {qd, gd, eof, sof} & m_ctl[5:2];
            if (wr_en) begin
                if (wr_addr == 3'd0) m_ctl = wr_data[5:0];
                else if (wr_addr <= 3'd5) m_stage[wr_addr] = wr_data;
            end
            for (int i = 1; i <= 5; i++) m_act[i] = m_new[i];
            m_st = nst; m_x = nx; m_y = ny;
        end
        exp_q.push_back(e);
    end

    // ---------------- monitor: pop expected, compare away from the edge ------
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(o_x == e.x, "R2", "dot position", o_x, e.x);
            check(o_y == e.y, "R2", "line position", o_y, e.y);
            check(o_hsync == e.hs, "R3", "hsync", o_hsync, e.hs);
            check(o_vsync == e.vs, "R3", "vsync", o_vsync, e.vs);
            check(o_de == e.de, "R4", "data enable", o_de, e.de);
            check(o_sof == e.sof, "R5", "start of frame", o_sof, e.sof);
            check(o_eof == e.eof, "R5", "end of frame", o_eof, e.eof);
            check(o_irq == e.irq, "R10", "event outputs", o_irq, e.irq);
        end
    end

    // ---------------- stimulus -----------------------------------------------
    initial begin
        forever begin
            @(negedge clk);
            case (pix_mode)
                0: pix_en = 1'b1;
                1: pix_en = (cyc % 3) != 0;
                default: pix_en = 1'($urandom % 2);
            endcase
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 60000) begin
                check(0, "WATCHDOG", "cycles", cyc, 60000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seen, maxx_pre, maxx_post, irqs, sofs;
        // R11: reset state
        wait_cycles(3);
        check(!o_hsync && !o_vsync && !o_de && o_x == 0 && o_y == 0 &&
              !o_sof && !o_eof && o_irq == 0, "R11", "outputs in reset",
              {o_hsync, o_vsync, o_de, o_sof, o_eof}, 0);
        rst_n = 1'b1;

        // R1: load timing set A through the write port while idle
        wr(3'd1, pr(0, 2));
        wr(3'd2, pr(0, 1));
        wr(3'd3, pr(10, 6));
        wr(3'd4, pr(3, 9));
        wr(3'd5, pr(2, 5));
        wait_cycles(2);
        check(o_x == 0 && !o_de && !o_sof, "R11", "idle after timing writes", o_x, 0);

        // R7: start with all events unmasked
        wr(3'd0, 32'h3D);
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            if (o_sof && o_x == 0 && o_y == 0) seen = 1;
            @(negedge clk);
        end
        check(seen == 1, "R7", "start-of-frame after enable", seen, 1);

        pix_mode = 1;
        wait_cycles(150);

        // R6: rewrite timing mid-frame (set B), old total must hold until wrap
        while (!(o_y == 1 && o_x == 4)) @(negedge clk);
        wr(3'd1, pr(1, 4));
        wr(3'd2, pr(1, 2));
        wr(3'd3, pr(14, 5));
        wr(3'd4, pr(5, 13));
        wr(3'd5, pr(2, 4));
        maxx_pre = 0;
        while (!o_sof) begin
            if (o_x > maxx_pre) maxx_pre = o_x;
            @(negedge clk);
        end
        @(negedge clk);
        maxx_post = 0;
        while (!o_sof) begin
            if (o_x > maxx_post) maxx_post = o_x;
            @(negedge clk);
        end
        check(maxx_pre == 9, "R1 R6", "old line length kept in frame", maxx_pre, 9);
        check(maxx_post == 13, "R1 R6", "new line length after wrap", maxx_post, 13);

        pix_mode = 2;
        wait_cycles(300);

        // R8: graceful stop
        wr(3'd0, 32'h3F);
        seen = 0;
        for (int i = 0; i < 1000 && seen == 0; i++) begin
            if (o_irq[2]) seen = 1;
            @(negedge clk);
        end
        check(seen == 1, "R8", "stop-done event", seen, 1);
        wait_cycles(10);
        check(o_x == 0 && o_y == 0 && !o_de && !o_sof, "R8", "idle after drained frame", o_x, 0);

        // R9: restart then quick stop
        pix_mode = 0;
        wr(3'd0, 32'h3D);
        wait_cycles(40);
        wr(3'd0, 32'h3C);
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            if (o_irq[3]) seen++;
            @(negedge clk);
        end
        check(seen == 1, "R9", "quick-done event count", seen, 1);
        check(o_x == 0 && !o_hsync && !o_vsync && !o_de, "R9", "outputs cleared", o_x, 0);

        // R10: run with every event masked
        pix_mode = 1;
        wr(3'd0, 32'h01);
        irqs = 0; sofs = 0;
        for (int i = 0; i < 300; i++) begin
            if (o_irq != 0) irqs++;
            if (o_sof) sofs++;
            @(negedge clk);
        end
        wr(3'd0, 32'h00);
        for (int i = 0; i < 5; i++) begin
            if (o_irq != 0) irqs++;
            @(negedge clk);
        end
        check(irqs == 0, "R10", "masked events on o_irq", irqs, 0);
        check(sofs >= 2, "R10", "frames ran while masked", sofs, 2);

        wait_cycles(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule